// File: doc/BRIEF.md
# Saturating Integer Add/Subtract Element

This block takes two integer elements, adds or subtracts them, and reduces the outcome to a chosen destination element width. It is meant to be instantiated once per lane of a vector integer datapath. Each operand is taken from the low bits of its input bus at the source element width (8, 16, 32 or 64 bits). It is widened to a signed or unsigned value according to the mode bit. The sum or difference is kept exact, so no information is lost at the larger of the source and destination widths. The block then narrows the value to the destination width.

With saturation enabled, a value outside the destination range is clamped to the nearest bound. The range is unsigned or signed, as the mode bit selects. With saturation disabled, the value wraps at the destination width. When condition recording is requested, a 4-bit condition field reports less-than, greater-than and equal-to-zero for the final result. Its overflow bit reports whether clamping took place for this element alone. Nothing is accumulated across elements. Asking for saturation while overflow-enable is set is a conflicting encoding, and the block raises an illegal-instruction flag for it.

The block has one register stage. Inputs presented with `in_valid` high appear on the outputs one clock later.

Top module: `sat_alu`

## Requirements
- R1: Operands are the low source-width bits of each input, widened by sign extension in signed mode and by zero extension in unsigned mode. The arithmetic is exact (no wrap) at the larger of source and destination width before reduction to the destination width. Width codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. `op_sub` = 0 adds and 1 subtracts (a minus b).
- R2: With `sat_en` = 1 and `signed_mode` = 0, a result above 2^d-1 becomes 2^d-1 and a result below zero becomes 0, where d is the destination width.
- R3: With `sat_en` = 1 and `signed_mode` = 1, a result is clamped to the range -2^(d-1) to 2^(d-1)-1, presented as a d-bit two's-complement pattern.
- R4: With `sat_en` = 0, the result is the low d bits of the exact value (wrap-around), and the overflow bit is 0.
- R5: Bits of `result` at and above the destination width are always 0.
- R6: `cond[0]` (overflow) is 1 exactly when `rc` = 1, `sat_en` = 1 and clamping happened for this element. It carries no state from earlier elements.
- R7: When `rc` = 1, `cond[3]` (lt), `cond[2]` (gt) and `cond[1]` (eq) compare the final d-bit result against zero. The comparison is signed in signed mode and unsigned otherwise, so lt is never set in unsigned mode. When `rc` = 0, `cond` is all zero.
- R8: `sat_en` = 1 together with `oe` = 1 sets `illegal` and forces `result` and `cond` to zero. `oe` = 1 without saturation is legal and computes normally.
- R9: Outputs change only on a clock edge where `in_valid` was high, one cycle after the inputs. `out_valid` follows `in_valid` with one cycle of delay. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opnd_a | input | 64 | First operand bus (low source-width bits used) |
| opnd_b | input | 64 | Second operand bus (low source-width bits used) |
| src_w | input | 2 | Source element width code |
| dst_w | input | 2 | Destination element width code |
| signed_mode | input | 1 | 1 = signed interpretation and clamping, 0 = unsigned |
| sat_en | input | 1 | Enable clamping to destination range |
| rc | input | 1 | Record the condition field |
| oe | input | 1 | Overflow-enable encoding bit (conflicts with saturation) |
| out_valid | output | 1 | Result registered from a valid input |
| result | output | 64 | Destination element, zero above destination width |
| cond | output | 4 | {lt, gt, eq, ov} |
| illegal | output | 1 | Saturation requested with overflow-enable set |

## Verification
The bench drives values one step past each bound at all four widths, including 64-bit cases whose exact sum needs a 65th bit. A design that kept only 64 bits would wrap there instead of clamping. Mixed-width cases check the following:
- A wide source narrowed to a small destination clamps rather than wraps. A design that computed at the destination width would return the low byte.
- A narrow signed source with junk in its upper bits is sign-extended from the correct bit.

Sign-sensitive flag cases show that the same bit pattern reports lt in signed mode and gt in unsigned mode. A saturating element followed by an in-range one shows that the overflow bit does not stick. The illegal combination, and the legal overflow-enable case next to it, catch a design that checks only one of the two bits.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
    localparam int NSIZES = 4;
    localparam int XLEN   = 8 << (NSIZES - 1);
    localparam int EXT    = XLEN + 2;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic ov;
    } cond_t;
endpackage

// File: rtl/sat_alu_extend.sv
module sat_alu_extend
    import sat_alu_pkg::*;
(
    input  logic [XLEN-1:0]       x,
    input  ew_e                   w,
    input  logic                  sgn,
    output logic signed [EXT-1:0] y
);
    logic signed [EXT-1:0] cand [0:NSIZES-1];

    // one widening variant per element size
    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        localparam int B = 8 << k;
        assign cand[k] = sgn ? {{(EXT-B){x[B-1]}}, x[B-1:0]}
                             : {{(EXT-B){1'b0}},   x[B-1:0]};
    end

    assign y = cand[w];
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp
    import sat_alu_pkg::*;
(
    input  logic signed [EXT-1:0] sum,
    input  ew_e                   dw,
    input  logic                  sgn,
    input  logic                  sat_en,
    output logic [XLEN-1:0]       res,
    output logic                  clipped
);
    logic signed [EXT-1:0] umax_t [0:NSIZES-1];
    logic signed [EXT-1:0] smax_t [0:NSIZES-1];
    logic signed [EXT-1:0] smin_t [0:NSIZES-1];

    for (genvar k = 0; k < NSIZES; k++) begin : g_bound
        localparam int B = 8 << k;
        assign umax_t[k] = {{(EXT-B){1'b0}}, {B{1'b1}}};
        assign smax_t[k] = {{(EXT-B+1){1'b0}}, {(B-1){1'b1}}};
        assign smin_t[k] = {{(EXT-B+1){1'b1}}, {(B-1){1'b0}}};
    end

    logic signed [EXT-1:0] hi, lo, picked, masked;
    logic                  over, under;

    always_comb begin
        hi     = sgn ? smax_t[dw] : umax_t[dw];
        lo     = sgn ? smin_t[dw] : '0;
        over   = sum > hi;
        under  = sum < lo;
        if (sat_en && over)       picked = hi;
        else if (sat_en && under) picked = lo;
        else                      picked = sum;
        masked  = picked & umax_t[dw];
        res     = masked[XLEN-1:0];
        clipped = sat_en && (over || under);
    end
endmodule

// File: rtl/sat_alu_flags.sv
module sat_alu_flags
    import sat_alu_pkg::*;
(
    input  logic [XLEN-1:0] res,
    input  ew_e             dw,
    input  logic            sgn,
    input  logic            rc,
    input  logic            clipped,
    output cond_t           cond
);
    logic [NSIZES-1:0] top_bit;

    for (genvar k = 0; k < NSIZES; k++) begin : g_sign
        assign top_bit[k] = res[(8 << k) - 1];
    end

    logic neg, zero;

    always_comb begin
        neg  = sgn && top_bit[dw];
        zero = (res == '0);
        cond = '0;
        if (rc) begin
            cond.lt = neg;
            cond.eq = zero;
            cond.gt = !neg && !zero;
            cond.ov = clipped;
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            op_sub,
    input  logic [63:0]     opnd_a,
    input  logic [63:0]     opnd_b,
    input  logic [1:0]      src_w,
    input  logic [1:0]      dst_w,
    input  logic            signed_mode,
    input  logic            sat_en,
    input  logic            rc,
    input  logic            oe,
    output logic            out_valid,
    output logic [63:0]     result,
    output logic [3:0]      cond,
    output logic            illegal
);
    ew_e sw_e, dw_e;
    assign sw_e = ew_e'(src_w);
    assign dw_e = ew_e'(dst_w);

    logic signed [EXT-1:0] ext_a, ext_b, exact;

    sat_alu_extend ext_a_i (.x(opnd_a), .w(sw_e), .sgn(signed_mode), .y(ext_a));
    sat_alu_extend ext_b_i (.x(opnd_b), .w(sw_e), .sgn(signed_mode), .y(ext_b));

    // exact sum: two spare bits cover any 64-bit add or subtract
    assign exact = op_sub ? (ext_a - ext_b) : (ext_a + ext_b);

    logic [XLEN-1:0] narrow;
    logic            clipped;

    sat_alu_clamp clamp_i (
        .sum(exact), .dw(dw_e), .sgn(signed_mode), .sat_en(sat_en),
        .res(narrow), .clipped(clipped)
    );

    cond_t cond_c;

    sat_alu_flags flags_i (
        .res(narrow), .dw(dw_e), .sgn(signed_mode), .rc(rc),
        .clipped(clipped), .cond(cond_c)
    );

    logic bad_enc;
    assign bad_enc = sat_en && oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cond      <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                illegal <= bad_enc;
                result  <= bad_enc ? '0 : narrow;
                cond    <= bad_enc ? '0 : cond_c;
            end
        end
    end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  dst_w,
    input logic        signed_mode,
    input logic        sat_en,
    input logic        rc,
    input logic        oe,
    input logic        out_valid,
    input logic [63:0] result,
    input logic [3:0]  cond,
    input logic        illegal
);
    logic [1:0] dw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dw_q <= '0;
        else if (in_valid) dw_q <= dst_w;
    end

    function automatic logic [63:0] low_mask(input logic [1:0] w);
        case (w)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sat_en && oe |=> illegal && result == '0 && cond == '0);

    // R6
    ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(sat_en && rc) |=> !cond[0]);

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result & ~low_mask(dw_q)) == '0);

    // R7
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(cond[3:1]));

    // R7
    rc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rc |=> cond == '0);

    // R2
    usat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rc && sat_en && !oe && !signed_mode
        |=> !cond[0] || result == '0 || result == low_mask(dw_q));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(cond));
endmodule

bind sat_alu sat_alu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_w(dst_w),
    .signed_mode(signed_mode), .sat_en(sat_en), .rc(rc), .oe(oe),
    .out_valid(out_valid), .result(result), .cond(cond), .illegal(illegal)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 18;

    typedef struct packed {
        logic [3:0]  req;
        logic        sub;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic        sg;
        logic        sat;
        logic        rc;
        logic        oe;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] er;
        logic [3:0]  ec;
        logic        ei;
    } vec_t;

    // cond = {lt, gt, eq, ov}
    localparam vec_t VEC [0:NVEC-1] = '{
        '{4'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'hF0, 64'h20, 64'hFF, 4'b0101, 1'b0}, // R2 high clamp
        '{4'd2, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h10, 64'h20, 64'h00, 4'b0011, 1'b0}, // R2 clamp to zero
        '{4'd3, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h70, 64'h20, 64'h7F, 4'b0101, 1'b0}, // R3 max
        '{4'd3, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h80, 64'h01, 64'h80, 4'b1001, 1'b0}, // R3 min
        '{4'd4, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'hF0, 64'h20, 64'h10, 4'b0100, 1'b0}, // R4 wrap
        '{4'd4, 1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h7FFF, 64'h1, 64'h8000, 4'b1000, 1'b0}, // R4 signed wrap
        '{4'd1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0100, 64'h1, 64'hFF, 4'b0101, 1'b0}, // R1 wide src
        '{4'd1, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEFF,
                                                         64'hFFFF_FFFF_FFFF_FF01, 64'h0, 4'b0010, 1'b0}, // R1 sign-ext
        '{4'd2, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
                                                         64'hFFFF_FFFF_FFFF_FFFF, 4'b0101, 1'b0}, // R2 64-bit
        '{4'd3, 1'b1, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h1,
                                                         64'h8000_0000_0000_0000, 4'b1001, 1'b0}, // R3 64-bit
        '{4'd7, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'hF0, 64'h20, 64'hFF, 4'b0000, 1'b0}, // R7 rc off
        '{4'd8, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 64'hF0, 64'h20, 64'h0, 4'b0000, 1'b1},  // R8 illegal
        '{4'd8, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h05, 64'h03, 64'h08, 4'b0100, 1'b0}, // R8 oe legal
        '{4'd5, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h1234, 64'h1, 64'h35, 4'b0100, 1'b0}, // R5 narrow
        '{4'd7, 1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 64'h5, 64'h7, 64'hFFFF_FFFE, 4'b1000, 1'b0}, // R7 signed lt
        '{4'd7, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 64'h5, 64'h7, 64'hFFFF_FFFE, 4'b0100, 1'b0}, // R7 unsigned gt
        '{4'd3, 1'b1, 2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'hFFFF_8000, 64'h1, 64'h8000, 4'b1001, 1'b0}, // R3 narrow min
        '{4'd6, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h7E, 64'h01, 64'h7F, 4'b0100, 1'b0}  // R6 edge, no ov
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [1:0]  src_w = '0;
    logic [1:0]  dst_w = '0;
    logic        signed_mode = 1'b0;
    logic        sat_en = 1'b0;
    logic        rc = 1'b0;
    logic        oe = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [3:0]  cond;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .src_w(src_w), .dst_w(dst_w),
        .signed_mode(signed_mode), .sat_en(sat_en), .rc(rc), .oe(oe),
        .out_valid(out_valid), .result(result), .cond(cond), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] last_r;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0 && result == '0 && cond == '0 && illegal == 1'b0,
              "R9", "reset state", {59'd0, out_valid, cond}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag       = $sformatf("R%0d", VEC[i].req);
            in_valid    = 1'b1;
            op_sub      = VEC[i].sub;
            src_w       = VEC[i].sw;
            dst_w       = VEC[i].dw;
            signed_mode = VEC[i].sg;
            sat_en      = VEC[i].sat;
            rc          = VEC[i].rc;
            oe          = VEC[i].oe;
            opnd_a      = VEC[i].a;
            opnd_b      = VEC[i].b;
            @(negedge clk);
            check(result == VEC[i].er, tag, $sformatf("vec %0d result", i), result, VEC[i].er);
            check(cond == VEC[i].ec, tag, $sformatf("vec %0d cond", i), {60'd0, cond}, {60'd0, VEC[i].ec});
            check(illegal == VEC[i].ei, tag, $sformatf("vec %0d illegal", i),
                  {63'd0, illegal}, {63'd0, VEC[i].ei});
            // R9 one-cycle latency
            check(out_valid == 1'b1, "R9", "out_valid high", {63'd0, out_valid}, 64'd1);
        end

        // R9 hold: idle input with changed operands leaves outputs alone
        last_r   = result;
        in_valid = 1'b0;
        opnd_a   = 64'hDEAD;
        opnd_b   = 64'h1;
        rc       = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid low when idle", {63'd0, out_valid}, 64'd0);
        check(result == last_r, "R9", "result held when idle", result, last_r);

        // R6 no sticky: a clamped op then an in-range op
        in_valid = 1'b1; op_sub = 1'b0; src_w = 2'd1; dst_w = 2'd1;
        signed_mode = 1'b0; sat_en = 1'b1; rc = 1'b1; oe = 1'b0;
        opnd_a = 64'hFFFF; opnd_b = 64'h2;
        @(negedge clk);
        check(cond == 4'b0101 && result == 64'hFFFF, "R6", "16-bit clamp sets ov",
              {cond, result[59:0]}, {4'b0101, 60'hFFFF});
        opnd_a = 64'h1; opnd_b = 64'h2;
        @(negedge clk);
        check(cond == 4'b0100 && result == 64'h3, "R6", "ov clears on next element",
              {cond, result[59:0]}, {4'b0100, 60'h3});

        // R9 reset mid-run clears outputs
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(result == '0 && cond == '0 && out_valid == 1'b0, "R9", "mid-run reset",
              result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule